// File: doc/BRIEF.md
# Channel-Status and User-Bit Serialiser

This block sits behind a biphase frame decoder in an audio receive path. For each decoded subframe the decoder hands over the channel-status bit, the user bit, a marker saying whether that subframe opened with the block-start preamble, and the channel it belongs to. The block sends both bits back out serially, one per subframe. Each bit is timed against the outgoing word clock, a fixed number of bit-clock ticks after each word-clock edge, so that a downstream controller can clock the bits in on the word clock.

A top-of-block pulse is raised with the first subframe of every block and held across eight word-clock periods. This gives the controller a wide marker for realigning its bit counters. Two channel-status flags are decoded from the left channel of each complete 192-frame block: the non-audio flag and the pre-emphasis flag. They are presented only when the next block begins. A decoder error blanks the outputs and abandons the block being collected. A separate force-low input blanks only the two serial bits.

All logic runs on one system clock. The bit clock is a one-cycle tick strobe, and the word clock is a level that changes in a tick cycle.

Top module: `cu_extractor`

## Requirements
- R1: Every subframe accepted on `sub_valid` before a word-clock edge is emitted exactly once, in arrival order. Its C bit appears on `cs_out` and its U bit on `ud_out`. Each value is held until the next subframe is emitted.
- R2: The serial outputs change only on the 17th `bit_tick` after a word-clock edge. The tick in the same cycle as the edge is not counted. After 16 ticks the previous value is still shown.
- R3: `blk_start` rises when a subframe marked with `sub_blk` is emitted. It stays high for 16 subframe emissions (eight word-clock periods) and falls when the 17th subframe is emitted.
- R4: `flag_nonaudio` is the C bit of the left subframe of frame 1, and `flag_emph` is the C bit of the left subframe of frame 3. Frame 0 is the frame that carries the block-start marker.
- R5: Both flags change only when a block-start subframe is emitted, and only if the preceding block reached frame 191. They then show that preceding block's values. At all other times they hold.
- R6: A block-start marker that arrives before frame 191 restarts frame counting and leaves both flags unchanged.
- R7: While `force_low` is high, `cs_out` and `ud_out` are low. `blk_start` and both flags are unaffected.
- R8: While `link_err` is high, `cs_out`, `ud_out` and `blk_start` are low and the block being collected is discarded. The next block-start marker after an error does not update the flags.
- R9: While `rst_n` is low, all five outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit-clock period |
| word_clk | input | 1 | Output word clock level; changes in a tick cycle |
| sub_valid | input | 1 | Strobe: a decoded subframe's bits are present |
| sub_c | input | 1 | Channel-status bit of the subframe |
| sub_u | input | 1 | User bit of the subframe |
| sub_blk | input | 1 | Subframe began with the block-start preamble |
| sub_right | input | 1 | Subframe is right channel (0 = left) |
| link_err | input | 1 | Decoder lock/error flag |
| force_low | input | 1 | Forces the serial C and U outputs low |
| cs_out | output | 1 | Serial channel-status bit |
| ud_out | output | 1 | Serial user bit |
| blk_start | output | 1 | Top-of-block pulse, eight word periods long |
| flag_nonaudio | output | 1 | Non-audio flag from the previous block |
| flag_emph | output | 1 | Pre-emphasis flag from the previous block |

## Verification
The bench probes the serial outputs one tick before and one tick after the 17-tick point. A delay counter that is off by one therefore shows up as a wrong value at one of the two probes. A stretch counter with the wrong length makes `blk_start` fall at the wrong subframe. The bench sends a short block that ends early, to catch a design that updates the flags without checking that the block is complete. It also raises an error inside the last frames of a full block, which catches a design that keeps its frame count through the error and then publishes the stale flags. Force-low is applied while the top-of-block pulse is high, which catches a design that blanks `blk_start` as well.

// File: rtl/cu_pkg.sv
package cu_pkg;
  typedef struct packed {
    logic c;
    logic u;
    logic blk;
    logic right;
  } sub_t;
endpackage

// File: rtl/cu_align.sv
module cu_align
  import cu_pkg::*;
#(
  parameter int DELAY_BITS = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic word_clk,
  input  logic sub_valid,
  input  sub_t sub_in,
  input  logic link_err,
  output logic emit,
  output sub_t emit_sub
);
  localparam int CW = $clog2(DELAY_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_BITS);

  logic          word_q, word_d;
  sub_t          pend_q, pend_d;
  sub_t          stg_q, stg_d;
  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          word_edge;

  assign word_edge = word_clk ^ word_q;

  always_comb begin
    word_d  = word_clk;
    pend_d  = sub_valid ? sub_in : pend_q;
    stg_d   = stg_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    emit    = 1'b0;
    if (link_err) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (word_edge) begin
      stg_d   = sub_valid ? sub_in : pend_q;
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && bit_tick) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_d == LAST) begin
        emit    = 1'b1;
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= 1'b0;
      pend_q  <= '0;
      stg_q   <= '0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      word_q  <= word_d;
      pend_q  <= pend_d;
      stg_q   <= stg_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign emit_sub = stg_q;
endmodule

// File: rtl/cu_stretch.sv
module cu_stretch #(
  parameter int STRETCH_WORDS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic emit,
  input  logic emit_blk,
  input  logic link_err,
  output logic active
);
  localparam int HALVES = 2 * STRETCH_WORDS;
  localparam int BW     = $clog2(HALVES + 1);

  logic [BW-1:0] bs_q, bs_d;

  always_comb begin
    bs_d = bs_q;
    if (link_err) begin
      bs_d = '0;
    end else if (emit) begin
      if (emit_blk) begin
        bs_d = BW'(HALVES);
      end else if (bs_q != '0) begin
        bs_d = bs_q - BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bs_q <= '0;
    else        bs_q <= bs_d;
  end

  assign active = (bs_q != '0);
endmodule

// File: rtl/cu_status.sv
module cu_status #(
  parameter int FRAMES  = 192,
  parameter int NA_BIT  = 1,
  parameter int EM_BIT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic emit,
  input  logic emit_c,
  input  logic emit_blk,
  input  logic emit_right,
  input  logic link_err,
  output logic flag_na,
  output logic flag_em
);
  localparam int FW = $clog2(FRAMES);
  localparam logic [FW-1:0] F_LAST = FW'(FRAMES - 1);
  localparam logic [FW-1:0] F_NA   = FW'(NA_BIT);
  localparam logic [FW-1:0] F_EM   = FW'(EM_BIT);

  logic          inblk_q, inblk_d;
  logic          full_q, full_d;
  logic [FW-1:0] frm_q, frm_d;
  logic          na_acc_q, na_acc_d;
  logic          em_acc_q, em_acc_d;
  logic          na_q, na_d;
  logic          em_q, em_d;

  always_comb begin
    inblk_d  = inblk_q;
    full_d   = full_q;
    frm_d    = frm_q;
    na_acc_d = na_acc_q;
    em_acc_d = em_acc_q;
    na_d     = na_q;
    em_d     = em_q;
    if (link_err) begin
      inblk_d = 1'b0;
      full_d  = 1'b0;
      frm_d   = '0;
    end else if (emit) begin
      if (emit_blk) begin
        if (full_q) begin
          na_d = na_acc_q;
          em_d = em_acc_q;
        end
        inblk_d = 1'b1;
        full_d  = 1'b0;
        frm_d   = '0;
      end else if (!emit_right && inblk_q && !full_q) begin
        frm_d = frm_q + FW'(1);
        if (frm_d == F_NA)   na_acc_d = emit_c;
        if (frm_d == F_EM)   em_acc_d = emit_c;
        if (frm_d == F_LAST) full_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inblk_q  <= 1'b0;
      full_q   <= 1'b0;
      frm_q    <= '0;
      na_acc_q <= 1'b0;
      em_acc_q <= 1'b0;
      na_q     <= 1'b0;
      em_q     <= 1'b0;
    end else begin
      inblk_q  <= inblk_d;
      full_q   <= full_d;
      frm_q    <= frm_d;
      na_acc_q <= na_acc_d;
      em_acc_q <= em_acc_d;
      na_q     <= na_d;
      em_q     <= em_d;
    end
  end

  assign flag_na = na_q;
  assign flag_em = em_q;
endmodule

// File: rtl/cu_extractor.sv
module cu_extractor
  import cu_pkg::*;
#(
  parameter int DELAY_BITS    = 17,
  parameter int STRETCH_WORDS = 8,
  parameter int FRAMES        = 192,
  parameter int NA_BIT        = 1,
  parameter int EM_BIT        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic word_clk,
  input  logic sub_valid,
  input  logic sub_c,
  input  logic sub_u,
  input  logic sub_blk,
  input  logic sub_right,
  input  logic link_err,
  input  logic force_low,
  output logic cs_out,
  output logic ud_out,
  output logic blk_start,
  output logic flag_nonaudio,
  output logic flag_emph
);
  sub_t sub_in;
  sub_t emit_sub;
  logic emit;
  logic bs_active;
  logic cs_q, cs_d;
  logic ud_q, ud_d;

  assign sub_in = '{c: sub_c, u: sub_u, blk: sub_blk, right: sub_right};

  cu_align #(.DELAY_BITS(DELAY_BITS)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .word_clk (word_clk),
    .sub_valid(sub_valid),
    .sub_in   (sub_in),
    .link_err (link_err),
    .emit     (emit),
    .emit_sub (emit_sub)
  );

  cu_stretch #(.STRETCH_WORDS(STRETCH_WORDS)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .emit    (emit),
    .emit_blk(emit_sub.blk),
    .link_err(link_err),
    .active  (bs_active)
  );

  cu_status #(.FRAMES(FRAMES), .NA_BIT(NA_BIT), .EM_BIT(EM_BIT)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .emit      (emit),
    .emit_c    (emit_sub.c),
    .emit_blk  (emit_sub.blk),
    .emit_right(emit_sub.right),
    .link_err  (link_err),
    .flag_na   (flag_nonaudio),
    .flag_em   (flag_emph)
  );

  always_comb begin
    cs_d = cs_q;
    ud_d = ud_q;
    if (link_err) begin
      cs_d = 1'b0;
      ud_d = 1'b0;
    end else if (emit) begin
      cs_d = emit_sub.c;
      ud_d = emit_sub.u;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      ud_q <= 1'b0;
    end else begin
      cs_q <= cs_d;
      ud_q <= ud_d;
    end
  end

  assign cs_out    = cs_q & ~force_low & ~link_err;
  assign ud_out    = ud_q & ~force_low & ~link_err;
  assign blk_start = bs_active & ~link_err;
endmodule

// File: rtl/cu_extractor_chk.sv
module cu_extractor_chk #(
  parameter int STRETCH_WORDS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic word_clk,
  input logic link_err,
  input logic force_low,
  input logic cs_out,
  input logic ud_out,
  input logic blk_start,
  input logic flag_nonaudio,
  input logic flag_emph
);
  localparam int MIN_EDGES = 2 * STRETCH_WORDS;
  localparam int HW = $clog2(MIN_EDGES + 2);

  logic          wq;
  logic          bs_q;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq     <= 1'b0;
      bs_q   <= 1'b0;
      hi_cnt <= '0;
    end else begin
      wq   <= word_clk;
      bs_q <= blk_start;
      if (blk_start && !bs_q) hi_cnt <= '0;
      else if (blk_start && (word_clk ^ wq) && hi_cnt != HW'(MIN_EDGES + 1))
        hi_cnt <= hi_cnt + HW'(1);
    end
  end

  // R7: forced-low mode blanks both serial bits
  p_force_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |-> (!cs_out && !ud_out));

  // R8: error blanks serial bits and block pulse
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |-> (!cs_out && !ud_out && !blk_start));

  // R2: serial bits move only on tick cycles
  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bit_tick) && !force_low && !link_err && !$past(force_low) && !$past(link_err))
      |-> ($stable(cs_out) && $stable(ud_out)));

  // R5: flags move only with a rising block pulse
  p_flags_at_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$stable(flag_nonaudio) || !$stable(flag_emph)) && !link_err) |-> $rose(blk_start));

  // R3: block pulse spans the full stretch
  p_stretch_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(blk_start) && !link_err && !$past(link_err)) |-> (hi_cnt >= HW'(MIN_EDGES)));
endmodule

bind cu_extractor cu_extractor_chk #(.STRETCH_WORDS(STRETCH_WORDS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .word_clk     (word_clk),
  .link_err     (link_err),
  .force_low    (force_low),
  .cs_out       (cs_out),
  .ud_out       (ud_out),
  .blk_start    (blk_start),
  .flag_nonaudio(flag_nonaudio),
  .flag_emph    (flag_emph)
);

// File: tb/cu_extractor_tb.sv
module cu_extractor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, word_clk = 1'b0, sub_valid = 1'b0;
  logic sub_c = 1'b0, sub_u = 1'b0, sub_blk = 1'b0, sub_right = 1'b0;
  logic link_err = 1'b0, force_low = 1'b0;
  logic cs_out, ud_out, blk_start, flag_nonaudio, flag_emph;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int m_bs = 0, m_frame = 0;
  bit m_inblk = 0, m_full = 0, m_na_acc = 0, m_em_acc = 0, m_na = 0, m_em = 0;
  bit m_c = 0, m_u = 0;

  always #5 clk = ~clk;

  cu_extractor u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .word_clk(word_clk),
    .sub_valid(sub_valid), .sub_c(sub_c), .sub_u(sub_u), .sub_blk(sub_blk),
    .sub_right(sub_right), .link_err(link_err), .force_low(force_low),
    .cs_out(cs_out), .ud_out(ud_out), .blk_start(blk_start),
    .flag_nonaudio(flag_nonaudio), .flag_emph(flag_emph)
  );

  task automatic chk(input logic act, input bit exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_gate(input bit v);
    return v & !force_low & !link_err;
  endfunction

  task automatic model_emit(input bit c, input bit u, input bit blk, input bit right);
    m_c = c;
    m_u = u;
    if (blk) m_bs = 16;
    else if (m_bs > 0) m_bs--;
    if (blk) begin
      if (m_full) begin m_na = m_na_acc; m_em = m_em_acc; end
      m_inblk = 1; m_full = 0; m_frame = 0;
    end else if (!right && m_inblk && !m_full) begin
      m_frame++;
      if (m_frame == 1) m_na_acc = c;
      if (m_frame == 3) m_em_acc = c;
      if (m_frame == 191) m_full = 1;
    end
  endtask

  task automatic send_sub(input bit c, input bit u, input bit blk, input bit right,
                          input string tcu, input string tfl);
    @(negedge clk);
    sub_valid = 1'b1; sub_c = c; sub_u = u; sub_blk = blk; sub_right = right;
    bit_tick = 1'b0;
    if (link_err) begin
      m_c = 0; m_u = 0; m_bs = 0; m_inblk = 0; m_full = 0; m_frame = 0;
    end
    @(negedge clk);
    sub_valid = 1'b0; bit_tick = 1'b1; word_clk = ~word_clk;
    @(negedge clk);
    bit_tick = 1'b0;
    for (int k = 1; k < 32; k++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      if (k == 16) begin
        chk(cs_out, exp_gate(m_c), "R2", "cs before tick 17");
        chk(ud_out, exp_gate(m_u), "R2", "ud before tick 17");
      end
      if (k == 17) begin
        if (!link_err) model_emit(c, u, blk, right);
        chk(cs_out, exp_gate(m_c), tcu, "cs");
        chk(ud_out, exp_gate(m_u), tcu, "ud");
        chk(blk_start, (m_bs != 0) && !link_err, "R3", "blk_start");
        chk(flag_nonaudio, m_na, tfl, "nonaudio");
        chk(flag_emph, m_em, tfl, "emph");
      end
    end
  endtask

  task automatic run_frames(input int n, input bit with_b, input bit na, input bit em,
                            input int f_lo, input int f_hi, input int e_lo, input int e_hi,
                            input string tfl);
    for (int f = 0; f < n; f++) begin
      bit lc;
      string tcu;
      force_low = (f >= f_lo && f <= f_hi);
      link_err  = (f >= e_lo && f <= e_hi);
      tcu = force_low ? "R7" : (link_err ? "R8" : "R1");
      lc = (f == 1) ? na : ((f == 3) ? em : 1'($urandom));
      send_sub(lc, 1'($urandom), with_b && f == 0, 1'b0, tcu, tfl);
      send_sub(1'($urandom), 1'($urandom), 1'b0, 1'b1, tcu, tfl);
    end
    force_low = 1'b0;
    link_err  = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    // R9: outputs low through reset while inputs move
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      bit_tick = 1'b1; word_clk = ~word_clk; sub_valid = 1'b1;
      sub_c = 1'b1; sub_u = 1'b1; sub_blk = 1'b1;
    end
    @(negedge clk);
    chk(cs_out, 1'b0, "R9", "cs in reset");
    chk(ud_out, 1'b0, "R9", "ud in reset");
    chk(blk_start, 1'b0, "R9", "blk in reset");
    chk(flag_nonaudio, 1'b0, "R9", "nonaudio in reset");
    chk(flag_emph, 1'b0, "R9", "emph in reset");
    bit_tick = 1'b0; sub_valid = 1'b0; sub_blk = 1'b0; sub_c = 1'b0; sub_u = 1'b0;
    word_clk = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // frames before any block start: flags hold (R5)
    run_frames(10, 1'b0, 1'b0, 1'b0, -1, -1, -1, -1, "R5");
    // full block: nonaudio=1, emph=1 collected
    run_frames(192, 1'b1, 1'b1, 1'b1, -1, -1, -1, -1, "R5");
    // short block: its start publishes the previous block's bits (R4)
    run_frames(40, 1'b1, 1'b0, 1'b0, -1, -1, -1, -1, "R4");
    // start after short block: flags unchanged (R6); force-low over block pulse (R7)
    run_frames(192, 1'b1, 1'b0, 1'b1, 2, 12, -1, -1, "R6");
    // full block publishes 0/1; error near its end discards it (R8)
    run_frames(192, 1'b1, 1'b1, 1'b0, -1, -1, 185, 187, "R5");
    // next start after the error: flags must stay 0/1 (R8)
    run_frames(5, 1'b1, 1'b0, 1'b0, -1, -1, -1, -1, "R8");
    summary();
  end
endmodule